// File: doc/BRIEF.md
# Supply-Droop Clock Period Adjuster

This block steers the period of a divided clock one output cycle at a time, so that the clock slows down while the supply sags. A ring of evenly spaced phases of a fast input clock is assumed, and the next output edge is named by a phase index. Several droop sensors each send a two-bit request (lengthen, shorten or keep). The block combines them into one adjustment of +2, +1, 0 or -1 phase steps. It then adds the nominal period plus that adjustment to the phase index, modulo the ring size. With 64 phases, one step is about 1.6 percent of a period.

One clock cycle of `clk` stands for one output edge. A request seen at one edge is registered, and it shapes the period computed at the following edge. A request therefore acts within two output cycles. A one-cycle lengthen request from a sensor lengthens exactly one period. The block also drives a pair of half-rate quadrature outputs for downstream buffers. A start-up control keeps everything quiet, with the phase index at zero, until it is raised.

Top module: `droop_period_adj`

## Requirements
- R1: While `rst_n` is low or `run` is low, the next clock edge leaves `phase_idx` at 0, `period_steps` at 0, and `edge_vld`, `clk_q0` and `clk_q90` all low.
- R2: When every sensor sends HOLD (code 2'b00), `period_steps` equals NOM_STEPS (64) and `phase_idx` keeps its value (advance 64 mod 64).
- R3: If exactly one sensor sends UP (code 2'b01), the period is NOM_STEPS+1 and the index advances by one extra step. This holds whatever the other sensors send, including DOWN.
- R4: If two or more sensors send UP, the period is NOM_STEPS+2.
- R5: DOWN (code 2'b10) shortens the period to NOM_STEPS-1 only when every sensor sends DOWN.
- R6: A mix of DOWN and HOLD, or any sensor sending the unused code 2'b11 with no UP present, gives the nominal period.
- R7: A request on `sens_req` at edge k is registered at edge k. It sets `period_steps` and moves `phase_idx` at edge k+1. The output sampled between k and k+1 still shows the old period. A one-cycle request affects exactly one period.
- R8: `phase_idx` wraps modulo PHASES: 0 minus one step gives 63, and 63 plus one step gives 0. Sensor i occupies bits [2i+1:2i] of `sens_req`.
- R9: Counting from edge 1, the first running edge after release, `clk_q0` toggles on odd-numbered edges and `clk_q90` on even-numbered ones. So `clk_q90` lags `clk_q0` by one output edge.
- R10: `edge_vld` is high after every edge taken with `run` high, starting at the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | one cycle per output edge |
| rst_n | input | 1 | synchronous reset, active low |
| run | input | 1 | start-up release; low keeps the block quiet |
| sens_req | input | 2*NSENS | sensor requests, 2 bits each: 00 hold, 01 up, 10 down, 11 hold |
| phase_idx | output | $clog2(PHASES) | ring phase chosen for the current edge |
| period_steps | output | $clog2(NOM_STEPS+3) | length of the current period in phase steps |
| edge_vld | output | 1 | an output edge was issued |
| clk_q0 | output | 1 | half-rate output, 0 degrees |
| clk_q90 | output | 1 | half-rate output, 90 degrees |

## Verification
The bench checks the combining rule where a careless priority would give the wrong answer. A single UP against three DOWNs must still lengthen the period, and a design that voted by majority would shorten it instead. Three DOWNs next to one HOLD, or next to the unused code, must stay nominal, where a design that treated any DOWN as decisive would shorten. The bench samples the cycle just after a request and expects no change yet. It then expects the change one cycle later and a return to nominal one cycle after that. A design that skipped the request register, or held the adjustment, fails one of those three samples. The bench also drives the index through zero in both directions, and it counts quadrature toggles from release so that a swapped start phase is caught.

// File: rtl/droop_period_adj.sv
`timescale 1ns/1ps
module droop_period_adj #(
  parameter int NSENS     = 4,
  parameter int PHASES    = 64,
  parameter int NOM_STEPS = 64,
  localparam int IW = $clog2(PHASES),
  localparam int PW = $clog2(NOM_STEPS + 3)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [2*NSENS-1:0] sens_req,
  output logic [IW-1:0]      phase_idx,
  output logic [PW-1:0]      period_steps,
  output logic               edge_vld,
  output logic               clk_q0,
  output logic               clk_q90
);
  localparam int CW = $clog2(NSENS + 1);

  logic [2*NSENS-1:0] req_q;
  logic [CW-1:0]      n_up;
  logic               all_dn;
  logic [PW-1:0]      step_nxt;
  logic               par;

  always_comb begin
    n_up   = '0;
    all_dn = 1'b1;
    for (int i = 0; i < NSENS; i++) begin
      if (req_q[2*i +: 2] == 2'b01) n_up = n_up + CW'(1);
      if (req_q[2*i +: 2] != 2'b10) all_dn = 1'b0;
    end
  end

  always_comb begin
    if (int'(n_up) >= 2)      step_nxt = PW'(NOM_STEPS + 2);
    else if (int'(n_up) == 1) step_nxt = PW'(NOM_STEPS + 1);
    else if (all_dn)          step_nxt = PW'(NOM_STEPS - 1);
    else                      step_nxt = PW'(NOM_STEPS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      req_q        <= '0;
      phase_idx    <= '0;
      period_steps <= '0;
      edge_vld     <= 1'b0;
      par          <= 1'b0;
      clk_q0       <= 1'b0;
      clk_q90      <= 1'b0;
    end else begin
      req_q        <= sens_req;
      period_steps <= step_nxt;
      phase_idx    <= phase_idx + step_nxt[IW-1:0];
      edge_vld     <= 1'b1;
      par          <= ~par;
      if (!par) clk_q0  <= ~clk_q0;
      else      clk_q90 <= ~clk_q90;
    end
  end
endmodule

// File: rtl/droop_period_adj_chk.sv
`timescale 1ns/1ps
module droop_period_adj_chk #(
  parameter int NSENS     = 4,
  parameter int PHASES    = 64,
  parameter int NOM_STEPS = 64,
  localparam int IW = $clog2(PHASES),
  localparam int PW = $clog2(NOM_STEPS + 3)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input logic [2*NSENS-1:0] sens_req,
  input logic [IW-1:0]      phase_idx,
  input logic [PW-1:0]      period_steps,
  input logic               edge_vld,
  input logic               clk_q0,
  input logic               clk_q90
);
  int  ups;
  logic dn_all;
  always_comb begin
    ups    = 0;
    dn_all = 1'b1;
    for (int i = 0; i < NSENS; i++) begin
      ups    = ups + ((sens_req[2*i +: 2] == 2'b01) ? 1 : 0);
      dn_all = dn_all & (sens_req[2*i +: 2] == 2'b10);
    end
  end

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (phase_idx == '0 && period_steps == '0 && !edge_vld && !clk_q0 && !clk_q90));

  p_one_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run, 2) && $past(run) && $past(ups, 2) == 1) |-> int'(period_steps) == NOM_STEPS + 1);

  p_multi_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run, 2) && $past(run) && $past(ups, 2) >= 2) |-> int'(period_steps) == NOM_STEPS + 2);

  p_all_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run, 2) && $past(run) && $past(dn_all, 2)) |-> int'(period_steps) == NOM_STEPS - 1);

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_vld && $past(edge_vld)) |-> phase_idx == IW'($past(phase_idx) + period_steps));

  p_quad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_vld && $past(edge_vld)) |-> $countones({clk_q0 ^ $past(clk_q0), clk_q90 ^ $past(clk_q90)}) == 1);

  p_vld_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> edge_vld);
endmodule

bind droop_period_adj droop_period_adj_chk #(.NSENS(NSENS), .PHASES(PHASES), .NOM_STEPS(NOM_STEPS)) u_chk (.*);

// File: tb/sim_droop_period_adj.sv
`timescale 1ns/1ps
module sim_droop_period_adj;
  localparam int NOM = 64;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [7:0] sens_req = 8'h00;
  logic [5:0] phase_idx;
  logic [6:0] period_steps;
  logic       edge_vld, clk_q0, clk_q90;
  int checks = 0;
  int errors = 0;

  droop_period_adj u0 (.clk(clk), .rst_n(rst_n), .run(run), .sens_req(sens_req),
    .phase_idx(phase_idx), .period_steps(period_steps), .edge_vld(edge_vld),
    .clk_q0(clk_q0), .clk_q90(clk_q90));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic quiet_check(input string tag);
    chk(phase_idx == 0, {tag, " phase_idx"}, phase_idx, 0);
    chk(period_steps == 0, {tag, " period_steps"}, period_steps, 0);
    chk(!edge_vld && !clk_q0 && !clk_q90, {tag, " vld/q0/q90"},
        {edge_vld, clk_q0, clk_q90}, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    quiet_check("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    quiet_check("R1 run low");
    run = 1'b1;
    @(negedge clk);
    chk(edge_vld, "R10 first edge vld", edge_vld, 1);
    chk(period_steps == NOM, "R2 first period", period_steps, NOM);
  endtask

  task automatic t_restart;
    run = 1'b0;
    @(negedge clk);
    quiet_check("R1 restart");
    run = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_hold;
    logic [5:0] base;
    @(negedge clk);
    base = phase_idx;
    repeat (4) begin
      @(negedge clk);
      chk(period_steps == NOM, "R2 hold period", period_steps, NOM);
      chk(phase_idx == base, "R2 hold index", phase_idx, base);
    end
  endtask

  task automatic pulse(input logic [7:0] r, input int adj, input string tag);
    logic [5:0] base, expi;
    base = phase_idx;
    expi = 6'(int'(base) + adj);
    sens_req = r;
    @(negedge clk);
    sens_req = 8'h00;
    chk(period_steps == NOM, {tag, " R7 not yet"}, period_steps, NOM);
    chk(phase_idx == base, {tag, " R7 index not yet"}, phase_idx, base);
    @(negedge clk);
    chk(int'(period_steps) == NOM + adj, {tag, " period"}, period_steps, NOM + adj);
    chk(phase_idx == expi, {tag, " index"}, phase_idx, expi);
    @(negedge clk);
    chk(period_steps == NOM, {tag, " R7 one-shot"}, period_steps, NOM);
    chk(phase_idx == expi, {tag, " R7 index held"}, phase_idx, expi);
  endtask

  task automatic t_combine;
    pulse(8'b00_00_00_01, 1, "R3 one up s0");
    pulse(8'b10_10_10_01, 1, "R3 up beats downs");
    pulse(8'b01_00_00_00, 1, "R3 one up s3");
    pulse(8'b00_01_00_01, 2, "R4 two up");
    pulse(8'b01_01_01_01, 2, "R4 all up");
    pulse(8'b10_10_10_10, -1, "R5 all down");
    pulse(8'b10_10_00_10, 0, "R6 down+hold");
    pulse(8'b10_10_10_11, 0, "R6 down+code11");
  endtask

  task automatic t_wrap;
    t_restart();
    pulse(8'b10_10_10_10, -1, "R8 0 to 63");
    chk(phase_idx == 63, "R8 at 63", phase_idx, 63);
    pulse(8'b00_00_01_00, 1, "R8 63 to 0");
    chk(phase_idx == 0, "R8 at 0", phase_idx, 0);
  endtask

  task automatic t_quad;
    run = 1'b0;
    @(negedge clk);
    quiet_check("R1 before quad");
    run = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk(edge_vld, "R10 vld", edge_vld, 1);
      chk(clk_q0 == (((k + 1) / 2) % 2 == 1), "R9 q0", clk_q0, ((k + 1) / 2) % 2);
      chk(clk_q90 == ((k / 2) % 2 == 1), "R9 q90", clk_q90, (k / 2) % 2);
    end
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_hold();
    t_combine();
    t_wrap();
    t_quad();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule